// File: doc/BRIEF.md
# Control Message Reassembler and Decoder

This block sits behind a byte-wide control channel whose sender may deliver a message in pieces of any length, with idle cycles between them. It collects bytes into 64-bit little-endian words and decodes each finished word as a protocol message. A sideband flag, sampled with the byte that completes a word, tells whether an out-of-band handle came with that message.

The first word opens the channel. It must equal the configured protocol version and must carry no handle; any other first word closes the channel for good. After the channel is open, each word is a signed position. The position and the handle flag together select one event: the node learns its own ID, a peer departs, the shared region is attached, or the next interrupt vector of a peer is registered. The block keeps a per-peer vector count, the number of known peers, the own ID and an attached flag. Each decoded word yields one registered strobe that is either an event or an error. Handles themselves are stored elsewhere.

Top module: `ctlmsg_decode_top`

## Requirements
- R1: After reset link_up, closed, own_valid, ev_valid, setup_valid and err_valid are 0, and peer_count equals INIT_PEERS.
- R2: Byte k of a word (k = 0..7, in arrival order) lands in bits 8k+7..8k. Idle cycles between bytes do not disturb the partial word. in_handle is sampled only with the eighth byte. The resulting strobe appears in the cycle after the eighth byte is accepted.
- R3: A first word equal to PROTO_VER with no handle sets link_up and raises no strobe.
- R4: A first word that differs from PROTO_VER, or that carries a handle, raises err_valid with err_code 1 and sets closed. closed holds until reset, and later bytes raise no strobe and change no state.
- R5: Once open, a position below -1, a position above 65535, or a non-negative position at or above PEER_SLOTS raises err_code 2 and changes no state. A handle-less -1 also raises err_code 2.
- R6: A handle-less position >= 0 that arrives while no own ID is held raises ev_kind 1 (own ID) with ev_pos set to the position. It sets own_valid and own_id, which then stay fixed until reset.
- R7: A handle-less position >= 0 that arrives once an own ID is held raises ev_kind 2 (departure) with ev_pos set to the position, and resets that peer's vector count to 0.
- R8: A handle with position -1 raises ev_kind 3 (attach) with ev_pos 16'hFFFF the first time. Every later one raises err_code 3.
- R9: A handle with position p >= 0 raises ev_kind 4 (vector) with ev_vec set to p's current count, then increments that count. When the count already equals MAX_VEC, it raises err_code 4 instead.
- R10: A vector registration whose position equals the held own ID also raises setup_valid in the same cycle, with ev_vec as the new vector index. setup_valid never appears without a vector event.
- R11: Every accepted non-negative position p sets peer_count to max(peer_count, p+1). peer_count never decreases.
- R12: Each decoded word on an open channel raises exactly one of ev_valid and err_valid, never both at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A byte is offered this cycle |
| in_byte | input | 8 | Channel byte |
| in_handle | input | 1 | A handle accompanies the message (sampled with the eighth byte) |
| ev_valid | output | 1 | Event strobe |
| ev_kind | output | 3 | 1 own ID, 2 departure, 3 attach, 4 vector |
| ev_pos | output | 16 | Position or ID of the event |
| ev_vec | output | CNT_W | Vector index for vector events, else 0 |
| setup_valid | output | 1 | Interrupt setup for own vector ev_vec |
| err_valid | output | 1 | Error strobe |
| err_code | output | 3 | 1 version, 2 bad position, 3 re-attach, 4 vectors full |
| link_up | output | 1 | Version accepted |
| closed | output | 1 | Channel closed after a bad first word |
| own_valid | output | 1 | Own ID assigned |
| own_id | output | 16 | Own ID |
| peer_count | output | PC_W | Current peer table size |

## Verification
Words are fed both as eight back-to-back bytes and as bursts with idle gaps. A spurious handle flag on the early bytes shows that only the eighth byte's flag counts, and a small position such as 19 tells correct byte order from reversed order, which would decode as an out-of-range value. Position patterns cover -5, -1 with and without a handle, in-range IDs, IDs past the table and past 16 bits, and repeated registrations up to and past the vector limit. These separate the classification branches from one another. Two opening sequences, one with a handle and one with a wrong version, separate the closing path from the normal start. A departure followed by a new registration shows that the count was cleared.

// File: rtl/ctlmsg_pkg.sv
package ctlmsg_pkg;

    typedef enum logic [2:0] {
        EV_NONE   = 3'd0,
        EV_OWN    = 3'd1,
        EV_DEPART = 3'd2,
        EV_ATTACH = 3'd3,
        EV_VECTOR = 3'd4
    } ev_kind_e;

    typedef enum logic [2:0] {
        ER_NONE     = 3'd0,
        ER_VERSION  = 3'd1,
        ER_BADPOS   = 3'd2,
        ER_REATTACH = 3'd3,
        ER_VFULL    = 3'd4
    } err_code_e;

    typedef enum logic [1:0] {
        ST_AWAIT  = 2'd0,
        ST_RUN    = 2'd1,
        ST_CLOSED = 2'd2
    } chan_state_e;

    localparam int unsigned WORD_BYTES = 8;
    localparam int unsigned WORD_BITS  = WORD_BYTES * 8;

endpackage

// File: rtl/ctlmsg_word_asm.sv
module ctlmsg_word_asm
    import ctlmsg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [7:0]           in_byte,
    input  logic                 in_handle,
    output logic                 word_valid,
    output logic [WORD_BITS-1:0] word,
    output logic                 word_handle
);
    localparam int unsigned CW = $clog2(WORD_BYTES);

    typedef struct packed {
        logic [WORD_BITS-1:0] lanes;
        logic [CW-1:0]        cnt;
    } asm_t;

    asm_t asm_d, asm_q;

    always_comb begin
        asm_d       = asm_q;
        word_valid  = 1'b0;
        word        = '0;
        word_handle = 1'b0;
        if (in_valid) begin
            if (asm_q.cnt == CW'(WORD_BYTES - 1)) begin
                word_valid  = 1'b1;
                word        = {in_byte, asm_q.lanes[WORD_BITS-9:0]};
                word_handle = in_handle;
                asm_d.cnt   = '0;
                asm_d.lanes = '0;
            end else begin
                asm_d.lanes[int'(asm_q.cnt)*8 +: 8] = in_byte;
                asm_d.cnt = asm_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) asm_q <= '0;
        else        asm_q <= asm_d;
    end

    assert_byte_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && asm_q.cnt != CW'(WORD_BYTES - 1)) |=> asm_q.cnt == $past(asm_q.cnt) + 1'b1);

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(asm_q));

endmodule

// File: rtl/ctlmsg_vec_table.sv
module ctlmsg_vec_table #(
    parameter int unsigned SLOTS   = 32,
    parameter int unsigned MAX_VEC = 4,
    localparam int unsigned IDX_W  = $clog2(SLOTS),
    localparam int unsigned CNT_W  = $clog2(MAX_VEC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CNT_W-1:0] rd_val,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [CNT_W-1:0] wr_val
);
    logic [CNT_W-1:0] cnt_d [SLOTS];
    logic [CNT_W-1:0] cnt_q [SLOTS];

    assign rd_val = cnt_q[rd_idx];

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        always_comb begin
            cnt_d[s] = cnt_q[s];
            if (wr_en && wr_idx == IDX_W'(s)) cnt_d[s] = wr_val;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) cnt_q[s] <= '0;
            else        cnt_q[s] <= cnt_d[s];
        end

        assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q[s] <= CNT_W'(MAX_VEC));
    end

endmodule

// File: rtl/ctlmsg_decoder.sv
module ctlmsg_decoder
    import ctlmsg_pkg::*;
#(
    parameter logic [63:0]  PROTO_VER  = 64'd0,
    parameter int unsigned  SLOTS      = 32,
    parameter int unsigned  INIT_PEERS = 16,
    parameter int unsigned  MAX_VEC    = 4,
    localparam int unsigned IDX_W      = $clog2(SLOTS),
    localparam int unsigned CNT_W      = $clog2(MAX_VEC + 1),
    localparam int unsigned PC_W       = $clog2(SLOTS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 word_valid,
    input  logic [WORD_BITS-1:0] word,
    input  logic                 word_handle,
    output logic [IDX_W-1:0]     tbl_idx,
    input  logic [CNT_W-1:0]     tbl_rd_val,
    output logic                 tbl_wr_en,
    output logic [CNT_W-1:0]     tbl_wr_val,
    output logic                 ev_valid,
    output logic [2:0]           ev_kind,
    output logic [15:0]          ev_pos,
    output logic [CNT_W-1:0]     ev_vec,
    output logic                 setup_valid,
    output logic                 err_valid,
    output logic [2:0]           err_code,
    output logic                 link_up,
    output logic                 closed,
    output logic                 own_valid,
    output logic [15:0]          own_id,
    output logic [PC_W-1:0]      peer_count
);
    typedef struct packed {
        chan_state_e      st;
        logic             attached;
        logic             own_valid;
        logic [15:0]      own_id;
        logic [PC_W-1:0]  peers;
        logic             ev_valid;
        ev_kind_e         ev_kind;
        logic [15:0]      ev_pos;
        logic [CNT_W-1:0] ev_vec;
        logic             setup_valid;
        logic             err_valid;
        err_code_e        err_code;
    } dec_t;

    dec_t dec_d, dec_q;

    logic            is_minus1;
    logic            pos_ok;
    logic [PC_W-1:0] pos_plus1;

    assign tbl_idx   = word[IDX_W-1:0];
    assign is_minus1 = (word == '1);
    assign pos_ok    = (word[WORD_BITS-1:16] == '0) && ({1'b0, word[15:0]} < 17'(SLOTS));
    assign pos_plus1 = PC_W'(word[IDX_W-1:0]) + 1'b1;

    always_comb begin
        dec_d             = dec_q;
        dec_d.ev_valid    = 1'b0;
        dec_d.ev_kind     = EV_NONE;
        dec_d.ev_pos      = '0;
        dec_d.ev_vec      = '0;
        dec_d.setup_valid = 1'b0;
        dec_d.err_valid   = 1'b0;
        dec_d.err_code    = ER_NONE;
        tbl_wr_en         = 1'b0;
        tbl_wr_val        = '0;

        if (word_valid) begin
            unique case (dec_q.st)
                ST_AWAIT: begin
                    if (!word_handle && word == PROTO_VER) begin
                        dec_d.st = ST_RUN;
                    end else begin
                        dec_d.st        = ST_CLOSED;
                        dec_d.err_valid = 1'b1;
                        dec_d.err_code  = ER_VERSION;
                    end
                end
                ST_RUN: begin
                    if (is_minus1) begin
                        if (!word_handle) begin
                            dec_d.err_valid = 1'b1;
                            dec_d.err_code  = ER_BADPOS;
                        end else if (dec_q.attached) begin
                            dec_d.err_valid = 1'b1;
                            dec_d.err_code  = ER_REATTACH;
                        end else begin
                            dec_d.attached = 1'b1;
                            dec_d.ev_valid = 1'b1;
                            dec_d.ev_kind  = EV_ATTACH;
                            dec_d.ev_pos   = 16'hFFFF;
                        end
                    end else if (!pos_ok) begin
                        dec_d.err_valid = 1'b1;
                        dec_d.err_code  = ER_BADPOS;
                    end else begin
                        if (pos_plus1 > dec_q.peers) dec_d.peers = pos_plus1;
                        if (!word_handle) begin
                            dec_d.ev_valid = 1'b1;
                            dec_d.ev_pos   = word[15:0];
                            if (!dec_q.own_valid) begin
                                dec_d.ev_kind   = EV_OWN;
                                dec_d.own_valid = 1'b1;
                                dec_d.own_id    = word[15:0];
                            end else begin
                                dec_d.ev_kind = EV_DEPART;
                                tbl_wr_en     = 1'b1;
                                tbl_wr_val    = '0;
                            end
                        end else if (tbl_rd_val >= CNT_W'(MAX_VEC)) begin
                            dec_d.err_valid = 1'b1;
                            dec_d.err_code  = ER_VFULL;
                        end else begin
                            dec_d.ev_valid    = 1'b1;
                            dec_d.ev_kind     = EV_VECTOR;
                            dec_d.ev_pos      = word[15:0];
                            dec_d.ev_vec      = tbl_rd_val;
                            tbl_wr_en         = 1'b1;
                            tbl_wr_val        = tbl_rd_val + 1'b1;
                            dec_d.setup_valid = dec_q.own_valid && (dec_q.own_id == word[15:0]);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q          <= '0;
            dec_q.st       <= ST_AWAIT;
            dec_q.own_id   <= 16'hFFFF;
            dec_q.peers    <= PC_W'(INIT_PEERS);
            dec_q.ev_kind  <= EV_NONE;
            dec_q.err_code <= ER_NONE;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign ev_valid    = dec_q.ev_valid;
    assign ev_kind     = dec_q.ev_kind;
    assign ev_pos      = dec_q.ev_pos;
    assign ev_vec      = dec_q.ev_vec;
    assign setup_valid = dec_q.setup_valid;
    assign err_valid   = dec_q.err_valid;
    assign err_code    = dec_q.err_code;
    assign link_up     = (dec_q.st == ST_RUN);
    assign closed      = (dec_q.st == ST_CLOSED);
    assign own_valid   = dec_q.own_valid;
    assign own_id      = dec_q.own_id;
    assign peer_count  = dec_q.peers;

    assert_single_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_valid && err_valid));

    assert_word_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && link_up) |=> (ev_valid || err_valid));

    assert_closed_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        closed |=> (closed && !ev_valid && !err_valid));

    assert_setup_vector_R10: assert property (@(posedge clk) disable iff (!rst_n)
        setup_valid |-> (ev_valid && ev_kind == 3'd4 && own_valid && ev_pos == own_id));

    assert_peers_monotonic_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 (peer_count >= $past(peer_count)));

    assert_own_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        own_valid |=> (own_valid && $stable(own_id)));

endmodule

// File: rtl/ctlmsg_decode_top.sv
module ctlmsg_decode_top #(
    parameter logic [63:0]  PROTO_VER  = 64'd0,
    parameter int unsigned  PEER_SLOTS = 32,
    parameter int unsigned  INIT_PEERS = 16,
    parameter int unsigned  MAX_VEC    = 4,
    localparam int unsigned CNT_W      = $clog2(MAX_VEC + 1),
    localparam int unsigned PC_W       = $clog2(PEER_SLOTS + 1),
    localparam int unsigned IDX_W      = $clog2(PEER_SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    input  logic             in_handle,
    output logic             ev_valid,
    output logic [2:0]       ev_kind,
    output logic [15:0]      ev_pos,
    output logic [CNT_W-1:0] ev_vec,
    output logic             setup_valid,
    output logic             err_valid,
    output logic [2:0]       err_code,
    output logic             link_up,
    output logic             closed,
    output logic             own_valid,
    output logic [15:0]      own_id,
    output logic [PC_W-1:0]  peer_count
);
    logic             w_valid;
    logic [63:0]      w_data;
    logic             w_handle;
    logic [IDX_W-1:0] t_idx;
    logic [CNT_W-1:0] t_rd;
    logic             t_we;
    logic [CNT_W-1:0] t_wv;

    ctlmsg_word_asm u_asm (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_byte     (in_byte),
        .in_handle   (in_handle),
        .word_valid  (w_valid),
        .word        (w_data),
        .word_handle (w_handle)
    );

    ctlmsg_vec_table #(
        .SLOTS   (PEER_SLOTS),
        .MAX_VEC (MAX_VEC)
    ) u_tbl (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (t_idx),
        .rd_val (t_rd),
        .wr_en  (t_we),
        .wr_idx (t_idx),
        .wr_val (t_wv)
    );

    ctlmsg_decoder #(
        .PROTO_VER  (PROTO_VER),
        .SLOTS      (PEER_SLOTS),
        .INIT_PEERS (INIT_PEERS),
        .MAX_VEC    (MAX_VEC)
    ) u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .word_valid  (w_valid),
        .word        (w_data),
        .word_handle (w_handle),
        .tbl_idx     (t_idx),
        .tbl_rd_val  (t_rd),
        .tbl_wr_en   (t_we),
        .tbl_wr_val  (t_wv),
        .ev_valid    (ev_valid),
        .ev_kind     (ev_kind),
        .ev_pos      (ev_pos),
        .ev_vec      (ev_vec),
        .setup_valid (setup_valid),
        .err_valid   (err_valid),
        .err_code    (err_code),
        .link_up     (link_up),
        .closed      (closed),
        .own_valid   (own_valid),
        .own_id      (own_id),
        .peer_count  (peer_count)
    );

endmodule

// File: tb/sim_ctlmsg_decode_top.sv
module sim_ctlmsg_decode_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = '0;
    logic       in_handle = 1'b0;
    logic       ev_valid, setup_valid, err_valid, link_up, closed, own_valid;
    logic [2:0] ev_kind, err_code, ev_vec;
    logic [15:0] ev_pos, own_id;
    logic [5:0] peer_count;

    ctlmsg_decode_top u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_handle(in_handle), .ev_valid(ev_valid), .ev_kind(ev_kind),
        .ev_pos(ev_pos), .ev_vec(ev_vec), .setup_valid(setup_valid),
        .err_valid(err_valid), .err_code(err_code), .link_up(link_up),
        .closed(closed), .own_valid(own_valid), .own_id(own_id),
        .peer_count(peer_count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic        is_err;
        logic [2:0]  code;
        logic [15:0] pos;
        logic [2:0]  vec;
        logic        setup;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    task automatic expect_ev(input string tag, input logic [2:0] kind, input logic [15:0] pos,
                             input logic [2:0] vec, input logic setup);
        exp_q.push_back('{is_err: 1'b0, code: kind, pos: pos, vec: vec, setup: setup});
        tag_q.push_back(tag);
    endtask

    task automatic expect_err(input string tag, input logic [2:0] code);
        exp_q.push_back('{is_err: 1'b1, code: code, pos: 16'h0, vec: 3'h0, setup: 1'b0});
        tag_q.push_back(tag);
    endtask

    // Drive one word byte by byte; gap idle cycles between bytes; a stray
    // handle flag may be driven on early bytes to show only byte 8 counts.
    task automatic send_word(input logic [63:0] w, input logic h, input int gap, input logic stray);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            in_valid  = 1'b1;
            in_byte   = w[8*k +: 8];
            in_handle = (k == 7) ? h : stray;
            if (k != 7) begin
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    in_valid  = 1'b0;
                    in_handle = stray;
                end
            end
        end
        @(negedge clk);
        in_valid  = 1'b0;
        in_handle = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Monitor: pop and compare each strobe
    always @(negedge clk) begin
        if (rst_n && (ev_valid || err_valid)) begin
            if (exp_q.size() == 0) begin
                n_checks++;
                n_fail++;
                $display("FAIL R12 unexpected strobe: actual ev=%0b err=%0b expected none", ev_valid, err_valid);
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({t, " is_err"}, {31'b0, err_valid}, {31'b0, e.is_err});
                if (e.is_err) begin
                    check({t, " err_code"}, {29'b0, err_code}, {29'b0, e.code});
                end else begin
                    check({t, " ev_kind"}, {29'b0, ev_kind}, {29'b0, e.code});
                    check({t, " ev_pos"}, {16'b0, ev_pos}, {16'b0, e.pos});
                    check({t, " ev_vec"}, {29'b0, ev_vec}, {29'b0, e.vec});
                    check({t, " setup"}, {31'b0, setup_valid}, {31'b0, e.setup});
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        @(negedge clk);
        // R1 reset state
        check("R1 link_up", {31'b0, link_up}, 0);
        check("R1 closed", {31'b0, closed}, 0);
        check("R1 own_valid", {31'b0, own_valid}, 0);
        check("R1 strobes", {29'b0, ev_valid, setup_valid, err_valid}, 0);
        check("R1 peer_count", {26'b0, peer_count}, 16);

        // R4: version with handle closes the channel
        expect_err("R4 handle on version", 3'd1);
        send_word(64'd0, 1'b1, 0, 1'b0);
        check("R4 closed", {31'b0, closed}, 1);
        check("R4 link_up", {31'b0, link_up}, 0);
        send_word(64'd5, 1'b0, 0, 1'b0);
        send_word(64'd6, 1'b1, 1, 1'b0);
        check("R4 ignored own_valid", {31'b0, own_valid}, 0);
        check("R4 ignored peer_count", {26'b0, peer_count}, 16);
        check("R4 still closed", {31'b0, closed}, 1);

        // R4: wrong version value
        do_reset();
        expect_err("R4 wrong version", 3'd1);
        send_word(64'd1, 1'b0, 0, 1'b0);
        check("R4 closed after mismatch", {31'b0, closed}, 1);

        // R3 / R2: version in gapped bursts, stray handle on early bytes
        do_reset();
        send_word(64'd0, 1'b0, 3, 1'b1);
        check("R3 link_up", {31'b0, link_up}, 1);
        check("R2 R3 no strobe queue", exp_q.size(), 0);

        expect_err("R5 pos -5", 3'd2);
        send_word(64'hFFFF_FFFF_FFFF_FFFB, 1'b0, 1, 1'b0);

        expect_ev("R9 first vector peer3", 3'd4, 16'd3, 3'd0, 1'b0);
        send_word(64'd3, 1'b1, 2, 1'b0);

        expect_ev("R6 own id", 3'd1, 16'd7, 3'd0, 1'b0);
        send_word(64'd7, 1'b0, 0, 1'b0);
        check("R6 own_valid", {31'b0, own_valid}, 1);
        check("R6 own_id", {16'b0, own_id}, 7);

        expect_ev("R10 own vector 0", 3'd4, 16'd7, 3'd0, 1'b1);
        send_word(64'd7, 1'b1, 0, 1'b0);
        expect_ev("R10 own vector 1", 3'd4, 16'd7, 3'd1, 1'b1);
        send_word(64'd7, 1'b1, 1, 1'b0);

        expect_ev("R7 depart peer3", 3'd2, 16'd3, 3'd0, 1'b0);
        send_word(64'd3, 1'b0, 0, 1'b0);
        expect_ev("R7 count cleared", 3'd4, 16'd3, 3'd0, 1'b0);
        send_word(64'd3, 1'b1, 0, 1'b0);

        expect_ev("R11 grow to 21", 3'd4, 16'd20, 3'd0, 1'b0);
        send_word(64'd20, 1'b1, 0, 1'b0);
        check("R11 peer_count 21", {26'b0, peer_count}, 21);

        expect_err("R5 pos 40 past table", 3'd2);
        send_word(64'd40, 1'b1, 0, 1'b0);
        expect_err("R5 pos 70000", 3'd2);
        send_word(64'd70000, 1'b0, 0, 1'b0);
        check("R5 peer_count unchanged", {26'b0, peer_count}, 21);
        check("R5 own_id unchanged", {16'b0, own_id}, 7);

        expect_ev("R8 attach", 3'd3, 16'hFFFF, 3'd0, 1'b0);
        send_word(64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 0, 1'b0);
        expect_err("R8 reattach", 3'd3);
        send_word(64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 2, 1'b0);
        expect_err("R5 minus1 no handle", 3'd2);
        send_word(64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 0, 1'b0);

        for (int v = 1; v < 4; v++) begin
            expect_ev("R9 fill peer20", 3'd4, 16'd20, 3'(v), 1'b0);
            send_word(64'd20, 1'b1, 0, 1'b0);
        end
        expect_err("R9 vectors full", 3'd4);
        send_word(64'd20, 1'b1, 0, 1'b0);

        expect_ev("R2 byte order pos19", 3'd4, 16'd19, 3'd0, 1'b0);
        send_word(64'd19, 1'b1, 0, 1'b0);
        check("R11 no shrink", {26'b0, peer_count}, 21);

        expect_ev("R7 depart peer10", 3'd2, 16'd10, 3'd0, 1'b0);
        send_word(64'd10, 1'b0, 0, 1'b0);

        repeat (3) @(negedge clk);
        check("R12 all strobes seen", exp_q.size(), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule